// File: doc/BRIEF.md
# Interrupt File Priority Arbiter

This block holds the pending and enable state of one interrupt file and selects the most urgent interrupt in it. Each identity has one pending bit and one enable bit. Identity 0 is reserved and never fires. A smaller identity number means higher priority. An identity takes part in arbitration only when both of its bits are set and it lies below an optional priority threshold. The winning identity drives a single registered interrupt request toward the hart, and that request is gated by a delivery-enable bit.

Software reaches three control registers through a read-modify-write port that carries a per-bit write mask:

- **Delivery switch.** Turns the interrupt request on or off.
- **Threshold.** Sets the upper limit on which identities can win.
- **Claim register.** A read reports the current winner. A write with any nonzero mask retires that winner by clearing its pending bit.

A neighbouring message receiver raises pending bits through a set vector, and a neighbouring word-access unit loads the enable vector. Both vectors are visible at the outputs.

Top module: `ifile_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every pending bit, every enable bit, the threshold and the delivery switch. After reset all register reads return 0 and `irqOut` is 0.
- R2: The winner is the lowest identity i ≥ 1 whose pending bit and enable bit are both set. Identity 0 never wins.
- R3: The search limit is the threshold when the threshold is nonzero and no larger than NUM_IDS. Otherwise the limit is NUM_IDS. Only identities strictly below the limit can win.
- R4: Reading the claim register (select 2) returns the winner in bits [26:16] and again in bits [10:0], with all other bits 0. It returns 0 when there is no winner.
- R5: A write to select 2 with a nonzero mask clears the pending bit of the current winner, whatever the data. A zero mask, or the absence of a winner, leaves pending unchanged.
- R6: Select 0 (delivery) has only bit 0 writable, and reads return 0 in bits [31:1]. Select 1 (threshold) is an 11-bit field in bits [10:0]. Each bit of it changes only where the mask bit is 1.
- R7: `irqOut` equals (delivery switch AND a winner exists), computed from the state one clock earlier.
- R8: `setPending` ORs into the pending bits. A set of the same identity as a simultaneous claim wins, so the bit stays set. `enableLoad` replaces the enable bits with `enableIn`. Bit 0 of both pending and enable stays 0 regardless of these inputs.
- R9: Select 3 reads as 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regValid | input | 1 | Register write strobe for this cycle |
| regSel | input | 2 | Register select: 0 delivery, 1 threshold, 2 claim, 3 unused |
| regWrMask | input | 32 | Per-bit write mask |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read value of the selected register (old value during a write) |
| setPending | input | NUM_IDS | Pending-set pulses, one bit per identity |
| enableLoad | input | 1 | Load `enableIn` into the enable bits |
| enableIn | input | NUM_IDS | New enable vector |
| pendingOut | output | NUM_IDS | Current pending bits |
| enableOut | output | NUM_IDS | Current enable bits |
| irqOut | output | 1 | Registered external interrupt request |

## Verification
Assertions in the RTL check the following on every cycle:

- A reported winner is both pending and enabled.
- A claim without a competing set removes the winner's pending bit on the next cycle.
- The request stays low one cycle after delivery was off.
- Bit 0 of pending and enable never rises.
- The claim read value carries the same identity in both fields.
- The delivery read has no upper bits.
- The unused select reads zero.
- At most one write strobe fires at a time.

The threshold limit rule at its boundaries (at the winner, one above it, exactly NUM_IDS, above NUM_IDS, a masked partial write), the choice of the lowest identity among several, and the ignored data of a claim can only be shown by the bench's scenarios. The same holds for a set beating a claim and a claim with nothing pending.

// File: rtl/ifarb_pkg.sv
package ifarb_pkg;
  localparam int REG_W     = 32;
  localparam int ID_W      = 11;
  localparam int TOP_SHIFT = 16;

  typedef enum logic [1:0] {
    SEL_DELIV  = 2'd0,
    SEL_THRESH = 2'd1,
    SEL_TOP    = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic             wrDeliv;
    logic             wrThresh;
    logic             claim;
    logic [REG_W-1:0] wrMask;
    logic [REG_W-1:0] wrData;
  } ctlStrobe_t;
endpackage

// File: rtl/ifarb_ctrl.sv
module ifarb_ctrl
  import ifarb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    regValid,
  input  logic [1:0]              regSel,
  input  logic [REG_W-1:0]        regWrMask,
  input  logic [REG_W-1:0]        regWrData,
  input  logic                    delivState,
  input  logic [ID_W-1:0]         thrState,
  input  logic [ID_W-1:0]         topId,
  output ctlStrobe_t              strobe,
  output logic [REG_W-1:0]        regRdData
);
  regSel_e selE;
  assign selE = regSel_e'(regSel);

  always_comb begin
    strobe          = '0;
    strobe.wrMask   = regWrMask;
    strobe.wrData   = regWrData;
    strobe.wrDeliv  = regValid && (selE == SEL_DELIV);
    strobe.wrThresh = regValid && (selE == SEL_THRESH);
    strobe.claim    = regValid && (selE == SEL_TOP) && (|regWrMask);
  end

  always_comb begin
    regRdData = '0;
    case (selE)
      SEL_DELIV:  regRdData[0] = delivState;
      SEL_THRESH: regRdData[ID_W-1:0] = thrState;
      SEL_TOP: begin
        regRdData[ID_W-1:0]                   = topId;
        regRdData[TOP_SHIFT+ID_W-1:TOP_SHIFT] = topId;
      end
      default: regRdData = '0;
    endcase
  end

  assert_deliv_read_R6: assert property (@(posedge clk) disable iff (rst)
    (selE == SEL_DELIV) |-> (regRdData[REG_W-1:1] == '0));
  assert_top_fields_R4: assert property (@(posedge clk) disable iff (rst)
    (selE == SEL_TOP) |->
      (regRdData[TOP_SHIFT+ID_W-1:TOP_SHIFT] == regRdData[ID_W-1:0]));
  assert_unused_sel_R9: assert property (@(posedge clk) disable iff (rst)
    (selE == SEL_NONE) |-> (regRdData == '0));
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.wrDeliv, strobe.wrThresh, strobe.claim}));
endmodule

// File: rtl/ifarb_dpath.sv
module ifarb_dpath
  import ifarb_pkg::*;
#(
  parameter int NUM_IDS = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  ctlStrobe_t         strobe,
  input  logic [NUM_IDS-1:0] setPending,
  input  logic               enableLoad,
  input  logic [NUM_IDS-1:0] enableIn,
  output logic [NUM_IDS-1:0] pendingOut,
  output logic [NUM_IDS-1:0] enableOut,
  output logic               delivState,
  output logic [ID_W-1:0]    thrState,
  output logic [ID_W-1:0]    topId,
  output logic               irqOut
);
  localparam int IDX_W = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;

  logic [NUM_IDS-1:0] pendQ, enQ, pendD, enD, qualVec;
  logic               delivQ, irqQ;
  logic [ID_W-1:0]    thrQ;
  int                 limit;
  logic               claimHit;
  logic [IDX_W-1:0]   topIdx;

  always_comb begin
    if ((thrQ != '0) && (int'(thrQ) <= NUM_IDS)) limit = int'(thrQ);
    else                                         limit = NUM_IDS;
  end

  assign qualVec[0] = 1'b0;
  for (genvar g = 1; g < NUM_IDS; g++) begin : gQual
    assign qualVec[g] = pendQ[g] && enQ[g] && (g < limit);
  end

  always_comb begin
    topId = '0;
    for (int i = NUM_IDS - 1; i >= 1; i--) begin
      if (qualVec[i]) topId = ID_W'(i);
    end
  end

  assign topIdx   = topId[IDX_W-1:0];
  assign claimHit = strobe.claim && (topId != '0);

  always_comb begin
    pendD = pendQ;
    for (int i = 1; i < NUM_IDS; i++) begin
      if (claimHit && (topId == ID_W'(i))) pendD[i] = 1'b0;
    end
    pendD    = pendD | setPending;
    pendD[0] = 1'b0;
    enD      = enableLoad ? enableIn : enQ;
    enD[0]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ  <= '0;
      enQ    <= '0;
      delivQ <= 1'b0;
      thrQ   <= '0;
      irqQ   <= 1'b0;
    end else begin
      pendQ <= pendD;
      enQ   <= enD;
      if (strobe.wrDeliv)
        delivQ <= (delivQ & ~strobe.wrMask[0]) | (strobe.wrData[0] & strobe.wrMask[0]);
      if (strobe.wrThresh)
        thrQ <= (thrQ & ~strobe.wrMask[ID_W-1:0]) |
                (strobe.wrData[ID_W-1:0] & strobe.wrMask[ID_W-1:0]);
      irqQ <= delivQ && (topId != '0);
    end
  end

  assign pendingOut = pendQ;
  assign enableOut  = enQ;
  assign delivState = delivQ;
  assign thrState   = thrQ;
  assign irqOut     = irqQ;

  assert_winner_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (topId != '0) |-> (pendQ[topIdx] && enQ[topIdx]));
  assert_claim_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe.claim && (topId != '0) && (setPending == '0)) |=> !pendQ[$past(topIdx)]);
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(delivQ) |-> !irqQ);
  assert_bit0_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !pendQ[0] && !enQ[0]);
endmodule

// File: rtl/ifile_arbiter.sv
module ifile_arbiter
  import ifarb_pkg::*;
#(
  parameter int NUM_IDS = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               regValid,
  input  logic [1:0]         regSel,
  input  logic [31:0]        regWrMask,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_IDS-1:0] setPending,
  input  logic               enableLoad,
  input  logic [NUM_IDS-1:0] enableIn,
  output logic [NUM_IDS-1:0] pendingOut,
  output logic [NUM_IDS-1:0] enableOut,
  output logic               irqOut
);
  ctlStrobe_t      strobe;
  logic            delivState;
  logic [ID_W-1:0] thrState, topId;

  ifarb_ctrl uCtrl (
    .clk(clk), .rst(rst), .regValid(regValid), .regSel(regSel),
    .regWrMask(regWrMask), .regWrData(regWrData),
    .delivState(delivState), .thrState(thrState), .topId(topId),
    .strobe(strobe), .regRdData(regRdData)
  );

  ifarb_dpath #(.NUM_IDS(NUM_IDS)) uDpath (
    .clk(clk), .rst(rst), .strobe(strobe), .setPending(setPending),
    .enableLoad(enableLoad), .enableIn(enableIn),
    .pendingOut(pendingOut), .enableOut(enableOut),
    .delivState(delivState), .thrState(thrState), .topId(topId),
    .irqOut(irqOut)
  );
endmodule

// File: tb/sim_ifile_arbiter.sv
`timescale 1ns/1ps
module sim_ifile_arbiter;
  localparam int N = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         regValid = 1'b0;
  logic [1:0]   regSel = 2'd0;
  logic [31:0]  regWrMask = '0, regWrData = '0, regRdData;
  logic [N-1:0] setPending = '0, enableIn = '0, pendingOut, enableOut;
  logic         enableLoad = 1'b0, irqOut;

  always #2.5 clk = ~clk;

  ifile_arbiter #(.NUM_IDS(N)) u0 (
    .clk(clk), .rst(rst), .regValid(regValid), .regSel(regSel),
    .regWrMask(regWrMask), .regWrData(regWrData), .regRdData(regRdData),
    .setPending(setPending), .enableLoad(enableLoad), .enableIn(enableIn),
    .pendingOut(pendingOut), .enableOut(enableOut), .irqOut(irqOut)
  );

  typedef struct {
    int          kind;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    tests = 0, fails = 0;
  bit    done = 1'b0;

  // monitor: compares every queued expectation at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [63:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = {32'h0, regRdData};
          1: act = {63'h0, irqOut};
          2: act = pendingOut;
          default: act = enableOut;
        endcase
        tests++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expectItem(int kind, logic [63:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rdReg(logic [1:0] sel, logic [31:0] exp, string tag);
    regSel = sel; regValid = 1'b0;
    expectItem(0, {32'h0, exp}, tag);
    step();
  endtask

  task automatic wrReg(logic [1:0] sel, logic [31:0] mask, logic [31:0] data);
    regSel = sel; regWrMask = mask; regWrData = data; regValid = 1'b1;
    step();
    regValid = 1'b0;
  endtask

  task automatic chkIrq(logic exp, string tag);
    step();
    expectItem(1, {63'h0, exp}, tag);
    step();
  endtask

  task automatic chkVec(int kind, logic [63:0] exp, string tag);
    expectItem(kind, exp, tag);
    step();
  endtask

  task automatic pulsePend(logic [N-1:0] v);
    setPending = v; step(); setPending = '0;
  endtask

  task automatic loadEn(logic [N-1:0] v);
    enableIn = v; enableLoad = 1'b1; step(); enableLoad = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    rdReg(2'd0, 32'h0, "R1 delivery after reset");
    rdReg(2'd1, 32'h0, "R1 threshold after reset");
    rdReg(2'd2, 32'h0, "R1 top after reset");
    chkVec(2, 64'h0, "R1 pending after reset");
    chkVec(1, 64'h0, "R1 irq after reset");

    // R8 enable load and pending set, bit 0 ignored
    loadEn('1);
    chkVec(3, 64'hFFFF_FFFF_FFFF_FFFE, "R8 enable bit0 stays 0");
    pulsePend(64'h0000_0000_0000_0221);
    chkVec(2, 64'h0000_0000_0000_0220, "R8 pending bit0 stays 0");

    // R2 R4 lowest identity wins, packed fields
    rdReg(2'd2, 32'h0005_0005, "R2 R4 top is 5");
    chkIrq(1'b0, "R7 irq low with delivery off");

    // R6 delivery only bit 0
    wrReg(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rdReg(2'd0, 32'h1, "R6 delivery bit0 only");
    chkIrq(1'b1, "R7 irq high with winner and delivery");

    // R3 threshold boundaries
    wrReg(2'd1, 32'hFFFF_FFFF, 32'd5);
    rdReg(2'd2, 32'h0, "R3 threshold equal to winner hides it");
    chkIrq(1'b0, "R7 irq drops when filtered");
    wrReg(2'd1, 32'hFFFF_FFFF, 32'd6);
    rdReg(2'd2, 32'h0005_0005, "R3 threshold one above winner");
    wrReg(2'd1, 32'h0000_FFFF, 32'hFFFF_FFFF);
    rdReg(2'd1, 32'h0000_07FF, "R6 threshold field masked to 11 bits");
    rdReg(2'd2, 32'h0005_0005, "R3 threshold above count disables filter");
    wrReg(2'd1, 32'h0000_00FF, 32'h0);
    rdReg(2'd1, 32'h0000_0700, "R6 threshold partial mask");
    wrReg(2'd1, 32'hFFFF_FFFF, 32'd64);
    rdReg(2'd2, 32'h0005_0005, "R3 threshold equal to count");
    wrReg(2'd1, 32'hFFFF_FFFF, 32'd0);

    // R5 claim behaviour
    wrReg(2'd2, 32'h0, 32'hFFFF_FFFF);
    chkVec(2, 64'h0000_0000_0000_0220, "R5 zero mask claim no effect");
    wrReg(2'd2, 32'h0000_0001, 32'h0000_0123);
    chkVec(2, 64'h0000_0000_0000_0200, "R5 claim clears winner only");
    rdReg(2'd2, 32'h0009_0009, "R5 next winner is 9");

    // R8 set beats simultaneous claim of same identity
    regSel = 2'd2; regWrMask = 32'h1; regWrData = 32'h0; regValid = 1'b1;
    setPending = 64'h0000_0000_0000_0200;
    step();
    regValid = 1'b0; setPending = '0;
    chkVec(2, 64'h0000_0000_0000_0200, "R8 set wins over claim");

    // R5 claim with no winner
    loadEn(64'h0000_0000_0000_0020);
    rdReg(2'd2, 32'h0, "R5 no winner when disabled");
    wrReg(2'd2, 32'hFFFF_FFFF, 32'h0);
    chkVec(2, 64'h0000_0000_0000_0200, "R5 claim without winner no effect");

    // R9 unused select
    rdReg(2'd3, 32'h0, "R9 unused select reads 0");
    wrReg(2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rdReg(2'd0, 32'h1, "R9 unused write leaves delivery");
    rdReg(2'd1, 32'h0, "R9 unused write leaves threshold");

    // R2 highest identity boundary
    loadEn('1);
    wrReg(2'd2, 32'h1, 32'h0);
    pulsePend(64'h8000_0000_0000_0000);
    rdReg(2'd2, 32'h003F_003F, "R2 R4 top is 63");

    // R7 delivery off drops irq
    wrReg(2'd0, 32'h1, 32'h0);
    chkIrq(1'b0, "R7 irq low after delivery off");

    step();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule